// File: doc/BRIEF.md
# Presettable binary up/down counter

This block is a binary counter of parameterised width (four bits by default) that steps by one on each rising clock edge. One input sets the direction and an active-low enable gates the counting. An active-low load input presets the count from a data bus. The preset acts at once, without waiting for a clock edge, and it overrides every other operation. A synchronous active-high reset clears the count to zero when no load is active.

Two status outputs support chaining several stages. `tc` flags the last value in the current direction: all ones when counting up, zero when counting down. `rc_n` is an active-low pulse that is low during the clock's low phase while `tc` is high and counting is enabled. It can drive the clock of a following stage. A high level on the enable stops that pulse, so one enable can halt a whole chain.

Top module: `updown_counter`

## Requirements
- R1: With `pl_n` high, `rst` high at a rising clock edge sets `q` to 0.
- R2: While `pl_n` is low, `q` equals `d` without waiting for a clock edge and follows changes on `d`. The load overrides reset, counting and holding, and the loaded value stays in `q` after `pl_n` returns high.
- R3: With `pl_n` high, `rst` low and `ce_n` high, `q` keeps its value across a rising clock edge.
- R4: With `pl_n` high, `rst` low, `ce_n` low and `up_dn` = 0, `q` increases by one on each rising clock edge.
- R5: With `pl_n` high, `rst` low, `ce_n` low and `up_dn` = 1, `q` decreases by one on each rising clock edge.
- R6: The count wraps modulo 2^WIDTH: counting up from all ones gives 0, and counting down from 0 gives all ones.
- R7: `tc` is 1 exactly when (`q` is all ones and `up_dn` = 0) or (`q` = 0 and `up_dn` = 1). It depends only on `q` and `up_dn`, not on `ce_n` or the clock, and it drops as soon as `up_dn` flips.
- R8: `rc_n` is 0 exactly when `tc` = 1, `ce_n` = 0 and `clk` = 0. Otherwise it is 1, which gives one low pulse per clock low phase at terminal count.
- R9: `ce_n` = 1 holds `rc_n` at 1 even while `tc` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; counting acts on the rising edge |
| rst | input | 1 | Synchronous active-high clear |
| pl_n | input | 1 | Active-low asynchronous preset |
| ce_n | input | 1 | Active-low count enable |
| up_dn | input | 1 | Direction: 0 = up, 1 = down |
| d | input | WIDTH | Preset value |
| q | output | WIDTH | Current count |
| tc | output | 1 | Terminal count flag for the current direction |
| rc_n | output | 1 | Active-low ripple clock pulse at terminal count |

## Verification
The bench checks `q` one nanosecond after the load input falls, with no clock edge in between. A design that loads only on the clock would show the old count there. The bench also changes `d` while the load is held, to catch a design that captured only the first value. It runs through both wrap points and flips the direction while sitting at all ones. A design with a direction-blind terminal decode would keep `tc` high after the flip. `rc_n` is checked in both clock phases, and at terminal count with the enable high. A gate that ignored the clock or the enable would pulse in the wrong phase, or pulse while the chain is meant to be halted.

// File: rtl/updown_counter_pkg.sv
package updown_counter_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } count_dir_e;
endpackage

// File: rtl/updown_count_core.sv
module updown_count_core
  import updown_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pl_n,
  input  logic             ce_n,
  input  logic             up_dn,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  count_dir_e       dir;
  logic [WIDTH-1:0] cnt;

  assign dir = count_dir_e'(up_dn);

  always_ff @(posedge clk or negedge pl_n) begin
    if (!pl_n) begin
      cnt <= d;
    end else if (rst) begin
      cnt <= '0;
    end else if (!ce_n) begin
      if (dir == DIR_UP) cnt <= cnt + 1'b1;
      else               cnt <= cnt - 1'b1;
    end
  end

  // while the preset is held the output follows d directly
  assign q = pl_n ? cnt : d;

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(pl_n) && pl_n && $past(ce_n) && !$past(rst)) |-> cnt == $past(cnt));

  assert_step_up_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(pl_n && !ce_n && !rst && !up_dn) && pl_n) |-> cnt == WIDTH'($past(cnt) + 1));

  assert_step_down_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(pl_n && !ce_n && !rst && up_dn) && pl_n) |-> cnt == WIDTH'($past(cnt) - 1));

  assert_wrap_up_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(pl_n && !ce_n && !rst && !up_dn && cnt == TOP) && pl_n) |-> cnt == '0);

  assert_wrap_down_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(pl_n && !ce_n && !rst && up_dn && cnt == '0) && pl_n) |-> cnt == TOP);
endmodule

// File: rtl/updown_term_decode.sv
module updown_term_decode
  import updown_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             up_dn,
  output logic             tc
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  always_comb begin
    if (count_dir_e'(up_dn) == DIR_UP) tc = (q == TOP);
    else                               tc = (q == '0);
  end
endmodule

// File: rtl/updown_ripple_gate.sv
module updown_ripple_gate (
  input  logic clk,
  input  logic rst,
  input  logic tc,
  input  logic ce_n,
  output logic rc_n
);
  assign rc_n = ~(tc & ~ce_n & ~clk);

  assert_rc_needs_tc_R8: assert property (@(posedge clk) disable iff (rst)
    !rc_n |-> (tc && !ce_n));

  assert_rc_blocked_R9: assert property (@(posedge clk) disable iff (rst)
    ce_n |-> rc_n);
endmodule

// File: rtl/updown_counter.sv
module updown_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pl_n,
  input  logic             ce_n,
  input  logic             up_dn,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             tc,
  output logic             rc_n
);
  updown_count_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst(rst), .pl_n(pl_n), .ce_n(ce_n),
    .up_dn(up_dn), .d(d), .q(q)
  );

  updown_term_decode #(.WIDTH(WIDTH)) u_term (
    .q(q), .up_dn(up_dn), .tc(tc)
  );

  updown_ripple_gate u_ripple (
    .clk(clk), .rst(rst), .tc(tc), .ce_n(ce_n), .rc_n(rc_n)
  );

  assert_load_wins_R2: assert property (@(posedge clk)
    !pl_n |-> q == d);
endmodule

// File: tb/updown_counter_test.sv
module updown_counter_test;
  localparam int W = 4;
  localparam int MOD = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         pl_n = 1'b1;
  logic         ce_n = 1'b1;
  logic         up_dn = 1'b0;
  logic [W-1:0] d = '0;
  logic [W-1:0] q;
  logic         tc;
  logic         rc_n;

  int checks = 0;
  int fails = 0;
  int mq = 0;
  bit done = 0;

  always #4 clk = ~clk;

  updown_counter #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .pl_n(pl_n), .ce_n(ce_n), .up_dn(up_dn),
    .d(d), .q(q), .tc(tc), .rc_n(rc_n)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int exp_tc(input int v, input logic dir);
    return ((dir == 1'b0 && v == MOD - 1) || (dir == 1'b1 && v == 0)) ? 1 : 0;
  endfunction

  // entered 1 ns after a rising edge; leaves 1 ns after the next one
  task automatic cycle(input logic r, input logic pl, input logic ce, input logic ud,
                       input int dv, input string req);
    rst = r; pl_n = pl; ce_n = ce; up_dn = ud; d = W'(dv);
    if (!pl) mq = dv;
    #1;
    check(req, "q", int'(q), mq);
    check("R7", "tc", int'(tc), exp_tc(mq, ud));
    check("R8", "rc_n clk high", int'(rc_n), 1);
    @(negedge clk); #1;
    check(ce ? "R9" : "R8", "rc_n clk low", int'(rc_n),
          (exp_tc(mq, ud) == 1 && !ce) ? 0 : 1);
    @(posedge clk);
    if (!pl)      mq = dv;
    else if (r)   mq = 0;
    else if (!ce) mq = ud ? (mq + MOD - 1) % MOD : (mq + 1) % MOD;
    #1;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(posedge clk); @(posedge clk); #1;
    mq = 0;
    // R1 reset state
    cycle(0, 1, 1, 0, 0, "R1");
    // R4 count up through wrap (R6)
    for (int i = 0; i < 18; i++) cycle(0, 1, 0, 0, 0, (i == 15) ? "R6" : "R4");
    // R1 reset mid count
    cycle(1, 1, 0, 0, 0, "R1");
    cycle(0, 1, 1, 0, 0, "R1");
    // R2 load 15 then hold with tc high, rc_n suppressed (R9, R3)
    cycle(0, 0, 1, 0, 15, "R2");
    for (int i = 0; i < 3; i++) cycle(0, 1, 1, 0, 0, "R3");
    // R7 direction flip at all ones: tc must drop
    cycle(0, 1, 1, 1, 0, "R7");
    cycle(0, 1, 1, 0, 0, "R7");
    // R5 count down through wrap (R6)
    cycle(0, 0, 1, 1, 2, "R2");
    for (int i = 0; i < 5; i++) cycle(0, 1, 0, 1, 0, (i == 2) ? "R6" : "R5");
    // R2 load in the middle of counting, with reset asserted: load wins
    for (int i = 0; i < 3; i++) cycle(0, 1, 0, 0, 0, "R4");
    cycle(1, 0, 0, 0, 9, "R2");
    cycle(0, 1, 0, 0, 0, "R2");
    // R2 q follows d while preset is held
    rst = 0; ce_n = 0; up_dn = 0; d = 4'd3; pl_n = 0; #1;
    check("R2", "q immediate load", int'(q), 3);
    d = 4'd12; #1;
    check("R2", "q tracks d", int'(q), 12);
    @(posedge clk); #1;
    mq = 12;
    cycle(0, 1, 0, 0, 0, "R2");
    // R8 up count at terminal with enable: rc_n pulses low
    cycle(0, 0, 1, 0, 14, "R2");
    for (int i = 0; i < 3; i++) cycle(0, 1, 0, 0, 0, "R8");
    // R8 down terminal at zero
    cycle(0, 0, 1, 1, 0, "R2");
    cycle(0, 1, 0, 1, 0, "R8");
    cycle(0, 1, 1, 1, 0, "R9");
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule